// File: doc/BRIEF.md
# Commit-on-update packet transmit FIFO

This block is a transmit queue for 32-bit words. A host fills it through a handful of decoded register addresses. The address a word lands on says where that word sits in its packet: the opening word, a middle word, the closing word that also commits, or a lone word that is both opening and commit. Words of a packet under construction are staged out of reach of the reader. Only a write to a commit location hands the whole packet to the transmit side, so a transmitter that starts a packet can always finish it without underflow.

The host bus carries 16 data bits. A word is assembled from byte writes or half-word writes before it enters the store. The read side is a registered valid/ready stream with an end-of-packet flag. It is shared with a second packet source, a data mover. Between packets this queue wins, and within a packet the stream never switches source.

Top module: `pkt_commit_fifo`

## Requirements
- R1: After synchronous reset, out_valid is 0, overflow is 0 and no word is queued.
- R2: Word slots decode from wr_addr[7:2]: 50h opens a packet, 54h continues, 58h continues and commits, 60h is a single-word packet (opens and commits). Writes to any other slot are ignored.
- R3: With wr_size=0 (byte), a write at offset k (wr_addr[1:0]) places wr_data[7:0] in word bits [31-8k:24-8k], so offset 0 is the most significant byte. The word enters the store only on the byte write at offset 3.
- R4: With wr_size=1 (half), offset 0 loads bits [31:16] and offset 2 loads bits [15:0] and completes the word. A half write at an odd offset is ignored.
- R5: Stored words are not offered on the output until a commit write (58h or 60h) completes.
- R6: The word completed by a commit write carries out_eop=1. Every other word of the packet carries out_eop=0.
- R7: A word completed at an opening slot (50h or 60h) discards any uncommitted words of an earlier packet.
- R8: At a packet boundary, when committed words are queued and the data mover offers a word, the queued word is sent first. out_src is 0 for a queued word and 1 for a data-mover word. dm_ready is high only in a cycle where the data-mover word is taken into the output register.
- R9: Once a packet has started on the output, every further word comes from the same source until the word with out_eop=1.
- R10: While out_valid=1 and out_ready=0, out_valid, out_data, out_eop and out_src hold their values.
- R11: Capacity is DEPTH words (default 517), counting committed, staged and unread words. A word completed while the store is full is dropped, and overflow pulses high for one cycle right after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host byte address |
| wr_size | input | 1 | 0 = byte write, 1 = half-word write |
| wr_data | input | 16 | Host write data (bits [7:0] for byte writes) |
| overflow | output | 1 | One-cycle pulse: completed word dropped because the store was full |
| dm_valid | input | 1 | Data-mover word valid |
| dm_ready | output | 1 | Data-mover word accepted this cycle |
| dm_data | input | 32 | Data-mover word |
| dm_eop | input | 1 | Data-mover word ends its packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Transmitter accepts the output word |
| out_data | output | 32 | Output word |
| out_eop | output | 1 | Output word ends its packet |
| out_src | output | 1 | 0 = queued word, 1 = data-mover word |

## Verification
On every cycle the assertions check that the output holds its values under backpressure, that a packet never changes source on the output, that dm_ready appears only when the data-mover word can be taken, and that overflow is a single-cycle pulse. Other behaviours can only be shown by the bench's scenarios. These include how a word is assembled from byte and half writes, that staged words stay invisible, that an opening write discards a stale packet, the order of queued and data-mover packets at a boundary, and dropping at exactly DEPTH words.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  // word slot numbers (byte address >> 2)
  localparam logic [5:0] SLOT_OPEN   = 6'h14;
  localparam logic [5:0] SLOT_MID    = 6'h15;
  localparam logic [5:0] SLOT_CLOSE  = 6'h16;
  localparam logic [5:0] SLOT_SINGLE = 6'h18;

  typedef enum logic [2:0] {
    LOC_NONE,
    LOC_OPEN,
    LOC_MID,
    LOC_CLOSE,
    LOC_SINGLE
  } loc_e;
endpackage

// File: rtl/cf_host_asm.sv
module cf_host_asm
  import cf_pkg::*;
#(
  parameter int HADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [HADDR_W-1:0]         wr_addr,
  input  logic                       wr_size,
  input  logic [HALF_W-1:0]          wr_data,
  output logic                       word_done,
  output logic                       word_open,
  output logic                       word_commit,
  output logic [WORD_W-1:0]          word_data
);
  localparam int SLOT_W = HADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        off;
  loc_e              loc;
  logic [WORD_W-1:0] asm_q, merged;
  logic              lane_ok, lane_last, hit;

  always_comb begin
    slot = wr_addr[HADDR_W-1:2];
    off  = wr_addr[1:0];
    if      (slot == SLOT_W'(SLOT_OPEN))   loc = LOC_OPEN;
    else if (slot == SLOT_W'(SLOT_MID))    loc = LOC_MID;
    else if (slot == SLOT_W'(SLOT_CLOSE))  loc = LOC_CLOSE;
    else if (slot == SLOT_W'(SLOT_SINGLE)) loc = LOC_SINGLE;
    else                                   loc = LOC_NONE;

    merged    = asm_q;
    lane_ok   = 1'b0;
    lane_last = 1'b0;
    if (!wr_size) begin
      merged[{~off, 3'b000} +: 8] = wr_data[7:0];
      lane_ok   = 1'b1;
      lane_last = (off == 2'd3);
    end else if (!off[0]) begin
      if (off[1]) merged[HALF_W-1:0]      = wr_data;
      else        merged[WORD_W-1:HALF_W] = wr_data;
      lane_ok   = 1'b1;
      lane_last = off[1];
    end

    hit         = wr_en && (loc != LOC_NONE) && lane_ok;
    word_done   = hit && lane_last;
    word_open   = (loc == LOC_OPEN) || (loc == LOC_SINGLE);
    word_commit = (loc == LOC_CLOSE) || (loc == LOC_SINGLE);
    word_data   = merged;
  end

  always_ff @(posedge clk) begin
    if (rst)      asm_q <= '0;
    else if (hit) asm_q <= merged;
  end
endmodule

// File: rtl/cf_store.sv
module cf_store
  import cf_pkg::*;
#(
  parameter int DEPTH = 517
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_open,
  input  logic              push_commit,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic              avail,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_eop,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = WORD_W + 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;
  logic [PTR_W-1:0] pend_wp, cmt_wp, rd_ptr, base_wp, new_wp;
  logic [CNT_W-1:0] pend_cnt, cmt_cnt, base_cnt, new_cnt;
  logic             full, do_wr, ovf_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    base_cnt = push_open ? cmt_cnt : pend_cnt;
    base_wp  = push_open ? cmt_wp  : pend_wp;
    full     = (base_cnt == CNT_W'(DEPTH));
    do_wr    = push && !full;
    new_cnt  = base_cnt + 1'b1;
    new_wp   = nxt(base_wp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_wp  <= '0;
      cmt_wp   <= '0;
      rd_ptr   <= '0;
      pend_cnt <= '0;
      cmt_cnt  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q    <= push && full;
      pend_cnt <= (do_wr ? new_cnt : pend_cnt) - CNT_W'(pop);
      if (do_wr) pend_wp <= new_wp;
      if (do_wr && push_commit) begin
        cmt_cnt <= new_cnt - CNT_W'(pop);
        cmt_wp  <= new_wp;
      end else begin
        cmt_cnt <= cmt_cnt - CNT_W'(pop);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
    end
  end

  // storage array: write port and registered read port only
  always_ff @(posedge clk) begin
    if (do_wr) mem[base_wp] <= {push_commit, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_q <= '0;
    else if (pop) rd_q <= mem[rd_ptr];
  end

  assign avail    = (cmt_cnt != '0);
  assign rd_data  = rd_q[WORD_W-1:0];
  assign rd_eop   = rd_q[WORD_W];
  assign overflow = ovf_q;
endmodule

// File: rtl/cf_tx_arb.sv
module cf_tx_arb
  import cf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_avail,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_eop,
  output logic              fifo_pop,
  input  logic              dm_valid,
  input  logic [WORD_W-1:0] dm_data,
  input  logic              dm_eop,
  output logic              dm_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_eop,
  output logic              out_src
);
  logic              valid_q, src_q, busy_q, dm_eop_q;
  logic [WORD_W-1:0] dm_q;
  logic              eop_w, load, locked, pick_f, pick_d;

  always_comb begin
    eop_w  = src_q ? dm_eop_q : fifo_eop;
    load   = !valid_q || out_ready;
    locked = valid_q ? !eop_w : busy_q;
    pick_f = 1'b0;
    pick_d = 1'b0;
    if (load) begin
      if (locked) begin
        if (!src_q) pick_f = fifo_avail;
        else        pick_d = dm_valid;
      end else begin
        pick_f = fifo_avail;
        pick_d = !fifo_avail && dm_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      src_q    <= 1'b0;
      busy_q   <= 1'b0;
      dm_q     <= '0;
      dm_eop_q <= 1'b0;
    end else begin
      if (valid_q && out_ready) busy_q <= !eop_w;
      if (load) valid_q <= pick_f || pick_d;
      if (pick_f) src_q <= 1'b0;
      if (pick_d) begin
        src_q    <= 1'b1;
        dm_q     <= dm_data;
        dm_eop_q <= dm_eop;
      end
    end
  end

  assign fifo_pop  = pick_f;
  assign dm_ready  = pick_d;
  assign out_valid = valid_q;
  assign out_data  = src_q ? dm_q : fifo_data;
  assign out_eop   = eop_w;
  assign out_src   = src_q;
endmodule

// File: rtl/pkt_commit_fifo.sv
module pkt_commit_fifo
  import cf_pkg::*;
#(
  parameter int DEPTH   = 517,
  parameter int HADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [HADDR_W-1:0] wr_addr,
  input  logic               wr_size,
  input  logic [HALF_W-1:0]  wr_data,
  output logic               overflow,
  input  logic               dm_valid,
  output logic               dm_ready,
  input  logic [WORD_W-1:0]  dm_data,
  input  logic               dm_eop,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_eop,
  output logic               out_src
);
  logic              w_done, w_open, w_commit, f_avail, f_pop, f_eop;
  logic [WORD_W-1:0] w_data, f_data;

  cf_host_asm #(.HADDR_W(HADDR_W)) u_asm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .word_done(w_done), .word_open(w_open),
    .word_commit(w_commit), .word_data(w_data)
  );

  cf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(w_done), .push_open(w_open),
    .push_commit(w_commit), .push_data(w_data), .pop(f_pop),
    .avail(f_avail), .rd_data(f_data), .rd_eop(f_eop), .overflow(overflow)
  );

  cf_tx_arb u_arb (
    .clk(clk), .rst(rst), .fifo_avail(f_avail), .fifo_data(f_data),
    .fifo_eop(f_eop), .fifo_pop(f_pop), .dm_valid(dm_valid),
    .dm_data(dm_data), .dm_eop(dm_eop), .dm_ready(dm_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eop(out_eop), .out_src(out_src)
  );
endmodule

// File: rtl/cf_checker.sv
module cf_checker (
  input logic        clk,
  input logic        rst,
  input logic        overflow,
  input logic        dm_valid,
  input logic        dm_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_eop,
  input logic        out_src
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_eop) && $stable(out_src));

  assert_same_src_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_eop ##1 out_valid |-> out_src == $past(out_src));

  assert_dm_take_R8: assert property (@(posedge clk) disable iff (rst)
    dm_ready |-> dm_valid && (!out_valid || out_ready));

  assert_ovf_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);
endmodule

bind pkt_commit_fifo cf_checker u_chk (.*);

// File: tb/pkt_commit_fifo_tb.sv
module pkt_commit_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic        wr_size = 1'b0;
  logic [15:0] wr_data = '0;
  logic        overflow;
  logic        dm_valid = 1'b0;
  logic        dm_ready;
  logic [31:0] dm_data = '0;
  logic        dm_eop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_eop;
  logic        out_src;

  always #2 clk = ~clk;

  pkt_commit_fifo u_dut (.*);

  int total = 0;
  int bad = 0;
  int n_got = 0;
  logic [31:0] got_w [64];
  logic        got_e [64];
  logic        got_s [64];

  // {addr, size, data}
  localparam logic [24:0] WR_TAB [17] = '{
    {8'h50, 1'b1, 16'h1111}, {8'h52, 1'b1, 16'h2222},
    {8'h54, 1'b1, 16'h3333}, {8'h56, 1'b1, 16'h4444},
    {8'h58, 1'b1, 16'h5555}, {8'h5A, 1'b1, 16'h6666},
    {8'h60, 1'b0, 16'h00AB}, {8'h61, 1'b0, 16'h00CD},
    {8'h62, 1'b0, 16'h00EF}, {8'h63, 1'b0, 16'h0001},
    {8'h50, 1'b0, 16'h0012}, {8'h51, 1'b0, 16'h0034},
    {8'h52, 1'b0, 16'h0056}, {8'h53, 1'b0, 16'h0078},
    {8'h58, 1'b1, 16'h9ABC}, {8'h5A, 1'b0, 16'h00DE},
    {8'h5B, 1'b0, 16'h00F0}
  };
  // {eop, word}
  localparam logic [32:0] EXP_TAB [6] = '{
    {1'b0, 32'h11112222}, {1'b0, 32'h33334444}, {1'b1, 32'h55556666},
    {1'b1, 32'hABCDEF01}, {1'b0, 32'h12345678}, {1'b1, 32'h9ABCDEF0}
  };

  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready && n_got < 64) begin
      got_w[n_got] = out_data;
      got_e[n_got] = out_eop;
      got_s[n_got] = out_src;
      n_got++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input int idx, input logic [31:0] w, input logic e,
                             input logic s, input string tag);
    logic [33:0] act;
    act = (idx < n_got) ? {got_s[idx], got_e[idx], got_w[idx]} : '1;
    chk(act == {s, e, w}, tag, 64'(act), 64'({s, e, w}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; dm_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] w);
    host_wr(a, 1'b1, w[31:16]);
    host_wr(a + 8'd2, 1'b1, w[15:0]);
  endtask

  // call at a falling edge; returns at the falling edge after acceptance
  task automatic dm_send(input logic [31:0] d, input logic e);
    logic acc;
    dm_valid = 1'b1; dm_data = d; dm_eop = e;
    do begin
      #1;
      acc = dm_ready;
      @(negedge clk);
    end while (!acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(overflow == 1'b0, "R1 overflow after reset", 64'(overflow), 64'd0);
    repeat (4) @(negedge clk);
    chk(n_got == 0, "R1 nothing sent when empty", 64'(n_got), 64'd0);

    // table: R2 R3 R4 R6 assembly and packet marking
    s0 = n_got;
    for (int i = 0; i < 17; i++)
      host_wr(WR_TAB[i][24:17], WR_TAB[i][16], WR_TAB[i][15:0]);
    repeat (12) @(negedge clk);
    chk(n_got - s0 == 6, "R3 R4 table word count", 64'(n_got - s0), 64'd6);
    for (int i = 0; i < 6; i++)
      expect_word(s0 + i, EXP_TAB[i][31:0], EXP_TAB[i][32], 1'b0, "R3 R4 R6 table word");

    // R5 staged words invisible, R7 opening write discards stale packet
    do_reset();
    s0 = n_got;
    wr_word(8'h50, 32'hB0B0_0001);
    wr_word(8'h54, 32'hB0B0_0002);
    repeat (6) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && n_got == s0, "R5 uncommitted not offered",
        64'(out_valid), 64'd0);
    wr_word(8'h50, 32'hC0C0_0001);
    wr_word(8'h58, 32'hC0C0_0002);
    repeat (6) @(negedge clk);
    chk(n_got - s0 == 2, "R7 stale words dropped", 64'(n_got - s0), 64'd2);
    expect_word(s0,     32'hC0C0_0001, 1'b0, 1'b0, "R7 first of new packet");
    expect_word(s0 + 1, 32'hC0C0_0002, 1'b1, 1'b0, "R6 commit word eop");

    // R2 other slots ignored, R4 odd half ignored
    s0 = n_got;
    wr_word(8'h50, 32'hA1A1_0001);
    wr_word(8'h5C, 32'hDEAD_0001);
    wr_word(8'h70, 32'hDEAD_0002);
    host_wr(8'h55, 1'b1, 16'hFFFF);
    wr_word(8'h58, 32'hA1A1_0002);
    repeat (6) @(negedge clk);
    chk(n_got - s0 == 2, "R2 unmapped slots ignored", 64'(n_got - s0), 64'd2);
    expect_word(s0,     32'hA1A1_0001, 1'b0, 1'b0, "R2 word one");
    expect_word(s0 + 1, 32'hA1A1_0002, 1'b1, 1'b0, "R4 word two after odd half");

    // R8 R9 R10 priority, source lock, hold
    do_reset();
    s0 = n_got;
    out_ready = 1'b0;
    @(negedge clk);
    dm_send(32'hD000_0001, 1'b0);
    dm_valid = 1'b0;
    wr_word(8'h60, 32'hF000_0001);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid && out_data == 32'hD000_0001 && out_src == 1'b1,
        "R10 held under backpressure", 64'(out_data), 64'hD000_0001);
    @(negedge clk);
    fork
      begin
        dm_send(32'hD000_0002, 1'b1);
        dm_send(32'hD000_0003, 1'b1);
        dm_valid = 1'b0;
      end
      begin
        repeat (3) @(negedge clk);
        out_ready = 1'b1;
      end
    join
    repeat (6) @(negedge clk);
    chk(n_got - s0 == 4, "R8 word count", 64'(n_got - s0), 64'd4);
    expect_word(s0,     32'hD000_0001, 1'b0, 1'b1, "R9 mover packet start");
    expect_word(s0 + 1, 32'hD000_0002, 1'b1, 1'b1, "R9 mover packet kept");
    expect_word(s0 + 2, 32'hF000_0001, 1'b1, 1'b0, "R8 queued packet first");
    expect_word(s0 + 3, 32'hD000_0003, 1'b1, 1'b1, "R8 mover after queued");

    // R11 capacity and overflow
    do_reset();
    s0 = n_got;
    wr_word(8'h50, 32'h0000_0000);
    for (int i = 1; i < 517; i++) wr_word(8'h54, 32'(i));
    chk(overflow == 1'b0, "R11 no overflow at DEPTH words", 64'(overflow), 64'd0);
    chk(out_valid == 1'b0, "R5 full but uncommitted", 64'(out_valid), 64'd0);
    wr_word(8'h54, 32'hEEEE_EEEE);
    chk(overflow == 1'b1, "R11 overflow pulse", 64'(overflow), 64'd1);
    @(negedge clk);
    #1;
    chk(overflow == 1'b0, "R11 overflow one cycle", 64'(overflow), 64'd0);
    wr_word(8'h60, 32'hCAFE_F00D);
    chk(overflow == 1'b0, "R7 single word after rewind", 64'(overflow), 64'd0);
    repeat (6) @(negedge clk);
    chk(n_got - s0 == 1, "R11 only committed word sent", 64'(n_got - s0), 64'd1);
    expect_word(s0, 32'hCAFE_F00D, 1'b1, 1'b0, "R6 single word packet");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule